// File: doc/BRIEF.md
# Interrupt Entry and Return Frame Sequencer

This block moves a processor's program counter into and out of a byte-wide stack when an interrupt is taken and when its handler returns. An accepted hardware request or a software trap captures the current 24-bit PC (and in one mode an 8-bit status byte) into a return frame. The frame is pushed one byte per cycle, and the block then loads the vector address supplied on its input into the PC. A return request pops the same frame one byte per cycle, rebuilds the return address, and commits it to the PC only once the last byte has arrived.

A static mode input picks the frame format. In the short format two bytes are saved and the return always lands in the top 64 KB region of the address space. In the long format four bytes are saved in a fixed non-sequential order that includes the status byte. The long-format return restores the status byte and pulses a line that clears the pending request. An in-service register with one bit per priority level blocks requests at or below the level being served until that handler returns.

Top module: `irq_frame_seq`

## Requirements
- R1: With `mode_wide` low, an accepted entry pushes exactly two bytes on consecutive cycles, first PC[7:0] and then PC[15:8], using the PC sampled in the accept cycle.
- R2: With `mode_wide` low, a return pops two bytes and loads the PC with {8'hFF, first popped byte, second popped byte}. `stat_load` and `clr_pend` stay low.
- R3: With `mode_wide` high, an accepted entry pushes four bytes in this order: status, PC[23:16], PC[7:0], PC[15:8].
- R4: With `mode_wide` high, a return pops four bytes, taking them as PC[15:8], PC[7:0], PC[23:16] and then status. It loads the full 24-bit PC and, in the same cycle, pulses `stat_load` with the status byte on `stat_new` and pulses `clr_pend`.
- R5: The cycle after the last push, `pc_load` is high for one cycle with `pc_new` equal to the vector address sampled at accept. `busy` is high from the cycle after accept through that cycle and low in the cycle after it.
- R6: During a return, `pc_load` stays low while `pop_req` is high. The restored PC appears, with `pc_load` high, in the cycle after the final pop. Pushes and pops never occur in the same cycle.
- R7: `trap_req` starts the same entry sequence as a hardware request, at level LVL_N-1, whatever the in-service state.
- R8: A hardware request at level `irq_lvl` is accepted only when no in-service bit is set or `irq_lvl` is above the highest set bit. On acceptance that level's bit is set. A blocked request causes no push and leaves `busy` low.
- R9: A return clears only the highest set in-service bit, at the end of its `pc_load` cycle. All other bits are kept.
- R10: Requests presented while `busy` is high are ignored. They start no sequence and change no in-service bit.
- R11: During reset `busy`, `push_vld`, `pop_req`, `pc_load`, `stat_load`, `clr_pend` and `in_svc` are all zero.
- R12: When idle, simultaneous requests are served in the order trap, then an eligible hardware request, then return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | Static frame format: 0 two-byte, 1 four-byte |
| irq_req | input | 1 | Hardware interrupt request |
| irq_lvl | input | LVL_W | Priority level of `irq_req` |
| trap_req | input | 1 | Software trap request |
| reti_req | input | 1 | Return-from-interrupt request |
| cur_pc | input | PC_W | Return address to save |
| cur_stat | input | BYTE_W | Status byte to save (four-byte mode) |
| vec_addr | input | PC_W | Handler address to load on entry |
| push_vld | output | 1 | Push `push_data` onto the stack this cycle |
| push_data | output | BYTE_W | Byte being pushed |
| pop_req | output | 1 | Pop the stack top this cycle |
| pop_data | input | BYTE_W | Current stack top, valid while `pop_req` is high |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | PC_W | New PC value |
| stat_load | output | 1 | Load `stat_new` into the status register |
| stat_new | output | BYTE_W | Restored status byte |
| clr_pend | output | 1 | Clear the pending interrupt request |
| busy | output | 1 | An entry or return sequence is running |
| in_svc | output | LVL_N | In-service bit per priority level |

## Verification
The checker assumes that the stack beneath the block returns the bytes in the reverse order of the pushes. It also assumes that `mode_wide` changes only while the block is idle, and that a return is requested only with at least one in-service bit set. The bench's stack model is a plain last-in-first-out array driven only by `push_vld` and `pop_req`. The bench changes the mode only between complete entry/return pairs. Every return it issues is matched to an earlier entry. Stray requests are sent only when the block is busy or the level is blocked, which tests the hold-off and priority rules without breaking these assumptions.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_PUSH = 2'd1,
      SQ_POP  = 2'd2,
      SQ_DONE = 2'd3
   } sq_state_e;

   localparam int FRAME_MAX  = 4;
   localparam int FRAME_NRW  = 2;
   localparam int SLOT_W     = $clog2(FRAME_MAX);

endpackage

// File: rtl/irq_frame_pack.sv
module irq_frame_pack
   import irq_frame_pkg::*;
#(
   parameter int PC_W   = 24,
   parameter int BYTE_W = 8
) (
   input  logic                                  wide,
   input  logic [PC_W-1:0]                       pc,
   input  logic [BYTE_W-1:0]                     stat,
   output logic [FRAME_MAX-1:0][BYTE_W-1:0]      frm,
   output logic [SLOT_W-1:0]                     last_slot
);

   logic [BYTE_W-1:0] pc_lo, pc_mid, pc_hi;

   assign pc_lo  = pc[BYTE_W-1:0];
   assign pc_mid = pc[2*BYTE_W-1:BYTE_W];
   assign pc_hi  = pc[3*BYTE_W-1:2*BYTE_W];

   // slot k holds the k-th byte to be pushed
   always_comb begin
      frm = '0;
      if (wide) begin
         frm[0]    = stat;
         frm[1]    = pc_hi;
         frm[2]    = pc_lo;
         frm[3]    = pc_mid;
         last_slot = SLOT_W'(FRAME_MAX - 1);
      end else begin
         frm[0]    = pc_lo;
         frm[1]    = pc_mid;
         last_slot = SLOT_W'(FRAME_NRW - 1);
      end
   end

endmodule

// File: rtl/irq_frame_unpack.sv
module irq_frame_unpack
   import irq_frame_pkg::*;
#(
   parameter int PC_W   = 24,
   parameter int BYTE_W = 8
) (
   input  logic                                  wide,
   input  logic [FRAME_MAX-1:0][BYTE_W-1:0]      frm,
   output logic [PC_W-1:0]                       pc,
   output logic [BYTE_W-1:0]                     stat
);

   // slots mirror the push order, so the same layout as the packer applies
   always_comb begin
      if (wide) begin
         pc   = {frm[1], frm[3], frm[2]};
         stat = frm[0];
      end else begin
         pc   = {{BYTE_W{1'b1}}, frm[1], frm[0]};
         stat = '0;
      end
   end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
   parameter int LVL_N = 4,
   parameter int LVL_W = $clog2(LVL_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [LVL_W-1:0] set_lvl,
   input  logic             clr_en,
   output logic [LVL_N-1:0] in_svc,
   output logic             any_act,
   output logic [LVL_W-1:0] top_lvl
);

   always_comb begin
      top_lvl = '0;
      for (int i = 0; i < LVL_N; i++) begin
         if (in_svc[i]) top_lvl = LVL_W'(i);
      end
   end

   assign any_act = |in_svc;

   for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (set_en && set_lvl == LVL_W'(g))
            bit_q <= 1'b1;
         else if (clr_en && top_lvl == LVL_W'(g))
            bit_q <= 1'b0;
      end
      assign in_svc[g] = bit_q;
   end

endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
   import irq_frame_pkg::*;
#(
   parameter int PC_W   = 24,
   parameter int BYTE_W = 8,
   parameter int LVL_N  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_wide,
   input  logic                       irq_req,
   input  logic [$clog2(LVL_N)-1:0]   irq_lvl,
   input  logic                       trap_req,
   input  logic                       reti_req,
   input  logic [PC_W-1:0]            cur_pc,
   input  logic [BYTE_W-1:0]          cur_stat,
   input  logic [PC_W-1:0]            vec_addr,
   output logic                       push_vld,
   output logic [BYTE_W-1:0]          push_data,
   output logic                       pop_req,
   input  logic [BYTE_W-1:0]          pop_data,
   output logic                       pc_load,
   output logic [PC_W-1:0]            pc_new,
   output logic                       stat_load,
   output logic [BYTE_W-1:0]          stat_new,
   output logic                       clr_pend,
   output logic                       busy,
   output logic [LVL_N-1:0]           in_svc
);

   localparam int LVL_W    = $clog2(LVL_N);
   localparam int TRAP_LVL = LVL_N - 1;

   if (PC_W != 3 * BYTE_W) begin : g_bad_pc
      $error("irq_frame_seq: PC_W must equal three bytes");
   end
   if (LVL_N < 2) begin : g_bad_lvl
      $error("irq_frame_seq: LVL_N must be at least 2");
   end

   sq_state_e                          st_q;
   logic [SLOT_W-1:0]                  idx_q, last_q;
   logic [FRAME_MAX-1:0][BYTE_W-1:0]   frm_q;
   logic [PC_W-1:0]                    vec_q;
   logic                               ret_q, wide_q;

   logic [FRAME_MAX-1:0][BYTE_W-1:0]   pk_frm;
   logic [SLOT_W-1:0]                  pk_last;
   logic [PC_W-1:0]                    up_pc;
   logic [BYTE_W-1:0]                  up_stat;

   logic                               any_act;
   logic [LVL_W-1:0]                   top_lvl;
   logic                               idle, lvl_ok;
   logic                               take_trap, take_irq, take_ret, take_ent;
   logic [LVL_W-1:0]                   ent_lvl;
   logic                               svc_clr;

   irq_frame_pack #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_pack (
      .wide      (mode_wide),
      .pc        (cur_pc),
      .stat      (cur_stat),
      .frm       (pk_frm),
      .last_slot (pk_last)
   );

   irq_frame_unpack #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_unpack (
      .wide (wide_q),
      .frm  (frm_q),
      .pc   (up_pc),
      .stat (up_stat)
   );

   irq_svc_track #(.LVL_N(LVL_N), .LVL_W(LVL_W)) u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (take_ent),
      .set_lvl (ent_lvl),
      .clr_en  (svc_clr),
      .in_svc  (in_svc),
      .any_act (any_act),
      .top_lvl (top_lvl)
   );

   // acceptance: trap first, then an eligible hardware request, then return
   assign idle      = (st_q == SQ_IDLE);
   assign lvl_ok    = !any_act || (irq_lvl > top_lvl);
   assign take_trap = idle && trap_req;
   assign take_irq  = idle && !trap_req && irq_req && lvl_ok;
   assign take_ret  = idle && !trap_req && !take_irq && reti_req;
   assign take_ent  = take_trap || take_irq;
   assign ent_lvl   = take_trap ? LVL_W'(TRAP_LVL) : irq_lvl;
   assign svc_clr   = (st_q == SQ_DONE) && ret_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         idx_q  <= '0;
         last_q <= '0;
         frm_q  <= '0;
         vec_q  <= '0;
         ret_q  <= 1'b0;
         wide_q <= 1'b0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               idx_q <= '0;
               if (take_ent) begin
                  frm_q  <= pk_frm;
                  last_q <= pk_last;
                  vec_q  <= vec_addr;
                  ret_q  <= 1'b0;
                  wide_q <= mode_wide;
                  st_q   <= SQ_PUSH;
               end else if (take_ret) begin
                  last_q <= mode_wide ? SLOT_W'(FRAME_MAX - 1) : SLOT_W'(FRAME_NRW - 1);
                  ret_q  <= 1'b1;
                  wide_q <= mode_wide;
                  st_q   <= SQ_POP;
               end
            end
            SQ_PUSH: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == last_q) st_q <= SQ_DONE;
            end
            SQ_POP: begin
               frm_q[last_q - idx_q] <= pop_data;
               idx_q <= idx_q + 1'b1;
               if (idx_q == last_q) st_q <= SQ_DONE;
            end
            SQ_DONE: begin
               st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = !idle;
   assign push_vld  = (st_q == SQ_PUSH);
   assign push_data = frm_q[idx_q];
   assign pop_req   = (st_q == SQ_POP);
   assign pc_load   = (st_q == SQ_DONE);
   assign pc_new    = ret_q ? up_pc : vec_q;
   assign stat_load = svc_clr && wide_q;
   assign clr_pend  = svc_clr && wide_q;
   assign stat_new  = up_stat;

endmodule

// File: rtl/irq_frame_chk.sv
module irq_frame_chk #(
   parameter int PC_W   = 24,
   parameter int BYTE_W = 8,
   parameter int LVL_N  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_wide,
   input logic              push_vld,
   input logic              pop_req,
   input logic              pc_load,
   input logic [PC_W-1:0]   pc_new,
   input logic              stat_load,
   input logic              clr_pend,
   input logic              busy,
   input logic [LVL_N-1:0]  in_svc
);

   // R6: never push and pop in one cycle
   a_r6_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_vld && pop_req));

   // R6: restored PC not committed while bytes are still being popped
   a_r6_no_load_mid_pop: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req |-> !pc_load);

   // R5: a sequence ends right after its load cycle
   a_r5_load_ends: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !busy);

   // R4: pending clear and status restore only on a four-byte load
   a_r4_clr_wide: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pend |-> (mode_wide && pc_load && stat_load));

   // R2: short-format return lands in the top region
   a_r2_top_region: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && $past(pop_req) && !mode_wide) |->
         (pc_new[PC_W-1:2*BYTE_W] == {BYTE_W{1'b1}}));

   // R9: in-service state frozen inside a sequence until its load cycle ends
   a_r9_svc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pc_load) |=> $stable(in_svc));

   // R8: at most one in-service bit gained per cycle
   a_r8_one_set: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($countones(in_svc) <= $countones($past(in_svc)) + 1));

endmodule

bind irq_frame_seq irq_frame_chk #(.PC_W(PC_W), .BYTE_W(BYTE_W), .LVL_N(LVL_N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_wide (mode_wide),
   .push_vld  (push_vld),
   .pop_req   (pop_req),
   .pc_load   (pc_load),
   .pc_new    (pc_new),
   .stat_load (stat_load),
   .clr_pend  (clr_pend),
   .busy      (busy),
   .in_svc    (in_svc)
);

// File: tb/sim_irq_frame_seq.sv
module sim_irq_frame_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wide = 1'b0;
   logic        irq_req = 1'b0;
   logic [1:0]  irq_lvl = '0;
   logic        trap_req = 1'b0;
   logic        reti_req = 1'b0;
   logic [23:0] cur_pc = '0;
   logic [7:0]  cur_stat = '0;
   logic [23:0] vec_addr = '0;
   logic        push_vld, pop_req, pc_load, stat_load, clr_pend, busy;
   logic [7:0]  push_data, pop_data, stat_new;
   logic [23:0] pc_new;
   logic [3:0]  in_svc;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   irq_frame_seq u0 (
      .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .irq_req(irq_req),
      .irq_lvl(irq_lvl), .trap_req(trap_req), .reti_req(reti_req),
      .cur_pc(cur_pc), .cur_stat(cur_stat), .vec_addr(vec_addr),
      .push_vld(push_vld), .push_data(push_data), .pop_req(pop_req),
      .pop_data(pop_data), .pc_load(pc_load), .pc_new(pc_new),
      .stat_load(stat_load), .stat_new(stat_new), .clr_pend(clr_pend),
      .busy(busy), .in_svc(in_svc)
   );

   // plain LIFO stack model
   logic [7:0] stk [64];
   int sp = 0;
   assign pop_data = (sp > 0) ? stk[sp-1] : 8'h00;
   always @(posedge clk) begin
      if (!rst_n) sp <= 0;
      else if (push_vld) begin stk[sp] <= push_data; sp <= sp + 1; end
      else if (pop_req && sp > 0) sp <= sp - 1;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog act=%0d exp<=100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic        wide;
      logic        trap;
      logic [1:0]  lvl;
      logic [23:0] pc;
      logic [7:0]  st;
      logic [23:0] vec;
   } vec_t;

   localparam vec_t VT [0:5] = '{
      '{1'b0, 1'b0, 2'd1, 24'h123456, 8'h5A, 24'h000100},
      '{1'b1, 1'b0, 2'd2, 24'hABCDEF, 8'hC3, 24'h010200},
      '{1'b0, 1'b1, 2'd0, 24'hFE0010, 8'h00, 24'h000033},
      '{1'b1, 1'b1, 2'd0, 24'h000001, 8'hFF, 24'hFFFFF0},
      '{1'b1, 1'b0, 2'd0, 24'h7F8081, 8'h01, 24'h000008},
      '{1'b0, 1'b0, 2'd3, 24'hFFFFFF, 8'h77, 24'h000003}
   };

   // entry: expected frame derived from R1/R3, timing from R5
   task automatic run_entry(input bit wide, input bit trap, input bit irq,
                            input logic [1:0] lvl, input logic [23:0] pc,
                            input logic [7:0] st, input logic [23:0] vec,
                            input bit poke, input bit also_ret);
      logic [7:0] e [4];
      int n;
      string tg;
      mode_wide = wide; cur_pc = pc; cur_stat = st; vec_addr = vec;
      trap_req = trap; irq_req = irq; irq_lvl = lvl; reti_req = also_ret;
      @(negedge clk);
      trap_req = 0; irq_req = 0; reti_req = 0;
      cur_pc = 24'h5A5A5A; cur_stat = 8'hEE; vec_addr = 24'h000BAD;
      if (wide) begin
         e[0] = st; e[1] = pc[23:16]; e[2] = pc[7:0]; e[3] = pc[15:8]; n = 4; tg = "R3";
      end else begin
         e[0] = pc[7:0]; e[1] = pc[15:8]; e[2] = 0; e[3] = 0; n = 2; tg = "R1";
      end
      if (trap) tg = {tg, "/R7"};
      for (int k = 0; k < n; k++) begin
         chk({tg, " push_vld"}, push_vld, 1);
         chk({tg, " push_data"}, push_data, e[k]);
         if (poke && k == 0) begin trap_req = 1; irq_req = 1; irq_lvl = 2'd3; end
         @(negedge clk);
         trap_req = 0; irq_req = 0;
      end
      chk("R5 pc_load", pc_load, 1);
      chk("R5 pc_new vector", pc_new, vec);
      chk("R5 busy in load", busy, 1);
      chk("R1/R3 no extra push", push_vld, 0);
      @(negedge clk);
      chk("R5 idle after", busy, 0);
   endtask

   // return: expected PC from R2/R4, commit timing from R6
   task automatic run_ret(input bit wide, input logic [23:0] pc, input logic [7:0] st);
      int n;
      mode_wide = wide;
      n = wide ? 4 : 2;
      reti_req = 1;
      @(negedge clk);
      reti_req = 0;
      for (int k = 0; k < n; k++) begin
         chk("R6 pop_req", pop_req, 1);
         chk("R6 no early load", pc_load, 0);
         @(negedge clk);
      end
      chk("R6 load after last pop", pc_load, 1);
      if (wide) begin
         chk("R4 pc_new", pc_new, pc);
         chk("R4 stat_load", stat_load, 1);
         chk("R4 stat_new", stat_new, st);
         chk("R4 clr_pend", clr_pend, 1);
      end else begin
         chk("R2 pc_new", pc_new, {8'hFF, pc[15:0]});
         chk("R2 stat_load", stat_load, 0);
         chk("R2 clr_pend", clr_pend, 0);
      end
      @(negedge clk);
      chk("R6 idle after", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 busy", busy, 0);
      chk("R11 in_svc", in_svc, 0);
      chk("R11 push/pop", {push_vld, pop_req}, 0);
      chk("R11 loads", {pc_load, stat_load, clr_pend}, 0);
      rst_n = 1;
      @(negedge clk);

      // table walk: entry then matching return
      for (int i = 0; i < 6; i++) begin
         logic [3:0] eb;
         eb = VT[i].trap ? 4'b1000 : (4'b0001 << VT[i].lvl);
         run_entry(VT[i].wide, VT[i].trap, !VT[i].trap, VT[i].lvl,
                   VT[i].pc, VT[i].st, VT[i].vec, 1'b0, 1'b0);
         chk(VT[i].trap ? "R7 in_svc" : "R8 in_svc", in_svc, eb);
         chk("R1/R3 stack depth", sp, VT[i].wide ? 4 : 2);
         run_ret(VT[i].wide, VT[i].pc, VT[i].st);
         chk("R9 in_svc cleared", in_svc, 0);
         chk("R4 stack empty", sp, 0);
      end

      // nesting and blocking (R8, R9)
      run_entry(1'b0, 1'b0, 1'b1, 2'd1, 24'h001111, 8'h0, 24'h000200, 1'b0, 1'b0);
      chk("R8 lvl1 set", in_svc, 4'b0010);
      irq_req = 1; irq_lvl = 2'd1;
      @(negedge clk);
      irq_req = 0;
      chk("R8 same level blocked busy", busy, 0);
      chk("R8 same level blocked push", push_vld, 0);
      irq_req = 1; irq_lvl = 2'd0;
      @(negedge clk);
      irq_req = 0;
      chk("R8 lower level blocked", busy, 0);
      chk("R8 in_svc kept", in_svc, 4'b0010);
      run_entry(1'b0, 1'b0, 1'b1, 2'd2, 24'h002222, 8'h0, 24'h000300, 1'b0, 1'b0);
      chk("R8 nested set", in_svc, 4'b0110);
      run_ret(1'b0, 24'h002222, 8'h0);
      chk("R9 top bit only", in_svc, 4'b0010);
      run_ret(1'b0, 24'h001111, 8'h0);
      chk("R9 last bit", in_svc, 4'b0000);

      // requests during a sequence are ignored (R10)
      run_entry(1'b0, 1'b0, 1'b1, 2'd0, 24'h003333, 8'h0, 24'h000400, 1'b1, 1'b0);
      chk("R10 in_svc unchanged", in_svc, 4'b0001);
      chk("R10 stack depth", sp, 2);
      @(negedge clk);
      chk("R10 stays idle", busy, 0);
      run_ret(1'b0, 24'h003333, 8'h0);

      // same-cycle priority (R12)
      run_entry(1'b1, 1'b1, 1'b1, 2'd1, 24'h445566, 8'h99, 24'h000500, 1'b0, 1'b0);
      chk("R12 trap over irq", in_svc, 4'b1000);
      run_ret(1'b1, 24'h445566, 8'h99);
      run_entry(1'b0, 1'b0, 1'b1, 2'd1, 24'h000777, 8'h0, 24'h000600, 1'b0, 1'b0);
      run_entry(1'b0, 1'b0, 1'b1, 2'd2, 24'h000888, 8'h0, 24'h000700, 1'b0, 1'b1);
      chk("R12 irq over return", in_svc, 4'b0110);
      run_ret(1'b0, 24'h000888, 8'h0);
      run_ret(1'b0, 24'h000777, 8'h0);
      chk("R12 in_svc final", in_svc, 4'b0000);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule